// File: doc/BRIEF.md
# Lockable Security Control Register File

This block is the register set, seen from the bus, of a battery-backed security monitor. It keeps two sensor control words. The external one is carried over to a slow monitor clock domain; the internal one drives the internal sensors directly. It also keeps an alarm word, a read-only diagnostic word and a 32-bit timestamp. Each control word carries a one-way lock bit. Once that bit is set, the word cannot be changed again until the next battery-on reset (`bat_rst_n`), which is the only reset of the block.

The alarm word has two self-clearing trigger bits. One starts a destructive reset and the other starts a key wipe. Each trigger stays high until the hardware that carries out the operation reports that it is done. When a destructive reset is accepted, the current RTC seconds value is captured into the timestamp register. Event and per-pair detect flags are set only by hardware and are cleared by software. Writes to the external control word start a toggle handshake into the monitor domain. While that transfer is in progress, a read-only busy bit is high and further writes to that word are refused with an error pulse.

Top module: `secmon_regfile`

## Requirements
- R1: After a battery-on reset, reads return 0 at offsets 0x00, 0x04, 0x08 and 0x10, and 0x00000001 at 0x0C. `drs_req`, `wipe_req`, `int_ctrl` and `mon_ext_ctrl` are all 0.
- R2: A write to 0x00 that is accepted stores bits 29:0 and the lock bit 31, and sets the busy bit 30 from the next cycle. The value written to bit 30 has no effect.
- R3: Busy stays high until the stored bits 29:0 appear on `mon_ext_ctrl`. After that, busy reads 0.
- R4: A write to 0x00 while busy is high and the word is unlocked is ignored, and `wr_err` is 1 in the cycle after that write.
- R5: Once bit 31 of 0x00 or 0x04 is set, later writes to that word change nothing, including the lock bit itself, and they raise no `wr_err`.
- R6: A write to the unlocked word at 0x04 places bits 30:0 on `int_ctrl` from the next cycle.
- R7: Writing 1 to bit 0 of 0x08 raises `drs_req`. It stays high until a `drs_done` pulse and is low in the cycle after that pulse. Writing 0 to bit 0 has no effect.
- R8: The timestamp register (0x10) loads `rtc_sec` only when `drs_req` rises. A repeated trigger while `drs_req` is pending does not load it again, and writes to 0x10 are ignored.
- R9: Writing 1 to bit 1 of 0x08 raises `wipe_req` until a `wipe_done` pulse. This changes neither `drs_req` nor the timestamp.
- R10: A pulse on `evt_in[i]` sets bit 2+i of 0x08, and a pulse on `det_in[j]` sets bit 16+j. Writing 0 to such a bit clears it, and writing 1 to it has no effect. A hardware set wins over a clear in the same cycle.
- R11: At 0x0C, bit 0 is 1, bits 2..6 mirror bits 2..6 of 0x08, bit 7 is the OR of the detect flags, bits 16..21 mirror the detect flags, and bit 8 is set by a `key_xfer` pulse. Only a battery-on reset clears bit 8, and writes to 0x0C are ignored.
- R12: A battery-on reset clears both lock bits, so the control words can be written again afterwards.
- R13: A read returns data with `rd_valid` high in the cycle after `rd_en`. An unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| bat_rst_n | input | 1 | Battery-on reset, synchronous, active low |
| mon_clk | input | 1 | Slow monitor-domain clock |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid |
| wr_err | output | 1 | External control write refused while busy |
| evt_in | input | 11 | Event flag set pulses |
| det_in | input | 6 | Per-pair detect set pulses |
| drs_done | input | 1 | Destructive reset complete |
| wipe_done | input | 1 | Key wipe complete |
| key_xfer | input | 1 | Key transferred pulse |
| rtc_sec | input | 32 | RTC seconds value |
| drs_req | output | 1 | Destructive reset request |
| wipe_req | output | 1 | Key wipe request |
| int_ctrl | output | 31 | Internal sensor control word |
| mon_ext_ctrl | output | 30 | External control word in the monitor domain |

## Verification
Two functions can land in the same cycle: a hardware set of a sticky flag and a software write of 0 that clears the same flag. The bench drives `evt_in[0]` in the very cycle that a zero word is written to the alarm offset. It then expects the read-back to show only bit 2 still set, because every other flag must be cleared while the raced one must survive. A second collision occurs when a trigger is written again while the earlier request is still pending. In that case the bench checks that the timestamp keeps its first captured value, even though `rtc_sec` has moved on.

// File: rtl/secmon_pkg.sv
// Shared offsets and bit positions of the security control register file.
// Assumes a 32-bit data word; the alarm and diagnostic fields are fixed
// positions that the sensor logic around the block decodes.
package secmon_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_EXT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_INT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ALM  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_DIAG = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_TS   = 8'h10;

    localparam int ALM_DRS_BIT   = 0;
    localparam int ALM_WIPE_BIT  = 1;
    localparam int EVT_LSB       = 2;
    localparam int DET_LSB       = 16;

    localparam int DIAG_BOR_BIT    = 0;
    localparam int DIAG_MIRROR_N   = 5;
    localparam int DIAG_ANYDET_BIT = 7;
    localparam int DIAG_KEY_BIT    = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EXT,
        SEL_INT,
        SEL_ALM,
        SEL_DIAG,
        SEL_TS
    } reg_sel_e;
endpackage

// File: rtl/secmon_sync.sv
// Multi-flop synchronizer for one bit.
// Assumes d changes no faster than the destination clock can sample it.
// A low rst_n clears the chain on the next clock edge.
module secmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/secmon_lock_reg.sv
// Control word with a one-way lock bit.
// Once locked, wr_en is ignored until rst_n (battery-on reset) goes low.
module secmon_lock_reg #(
    parameter int W = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         lock_in,
    output logic [W-1:0] q,
    output logic         locked
);
    // Load the word and lock bit together while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            locked <= 1'b0;
        end else if (wr_en && !locked) begin
            q      <= wdata;
            locked <= lock_in;
        end
    end
endmodule

// File: rtl/secmon_ext_xfer.sv
// External control word with a busy handshake into the monitor domain.
// Bus side: a lockable word plus a request toggle. Monitor side: when the
// synchronized request differs from the ack toggle, the word is copied and
// the ack toggles. The word is stable while busy, since writes are refused.
// The monitor-domain reset is derived from rst_n through a synchronizer.
module secmon_ext_xfer #(
    parameter int W      = 30,
    parameter int SYNC_N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mon_clk,
    input  logic         wr_req,
    input  logic [W-1:0] wdata,
    input  logic         lock_in,
    output logic [W-1:0] ctrl_q,
    output logic         locked,
    output logic         busy,
    output logic         rejected,
    output logic [W-1:0] mon_ctrl
);
    logic accept;
    logic req_t;
    logic ack_t;
    logic ack_bus;
    logic req_mon;
    logic mon_rst_n;

    assign busy     = req_t ^ ack_bus;
    assign accept   = wr_req && !busy && !locked;
    assign rejected = wr_req && busy && !locked;

    secmon_lock_reg #(.W(W)) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wdata   (wdata),
        .lock_in (lock_in),
        .q       (ctrl_q),
        .locked  (locked)
    );

    // Flip the request toggle on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      req_t <= 1'b0;
        else if (accept) req_t <= ~req_t;
    end

    secmon_sync #(.STAGES(SYNC_N)) u_ack_sync (
        .clk (clk), .rst_n (rst_n), .d (ack_t), .q (ack_bus)
    );

    secmon_sync #(.STAGES(SYNC_N)) u_rst_sync (
        .clk (mon_clk), .rst_n (1'b1), .d (rst_n), .q (mon_rst_n)
    );

    secmon_sync #(.STAGES(SYNC_N)) u_req_sync (
        .clk (mon_clk), .rst_n (mon_rst_n), .d (req_t), .q (req_mon)
    );

    // Take up a pending word in the monitor domain and acknowledge it.
    always_ff @(posedge mon_clk) begin
        if (!mon_rst_n) begin
            ack_t    <= 1'b0;
            mon_ctrl <= '0;
        end else if (req_mon != ack_t) begin
            mon_ctrl <= ctrl_q;
            ack_t    <= req_mon;
        end
    end
endmodule

// File: rtl/secmon_alarm.sv
// Alarm word: self-clearing triggers, sticky hardware flags, timestamp
// capture and the diagnostic word. Assumes done pulses come only while the
// matching request is high. A hardware set beats a software clear.
module secmon_alarm #(
    parameter int DATA_W = 32,
    parameter int EVT_N  = 11,
    parameter int DET_N  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_trig,
    input  logic [EVT_N-1:0]  wr_evt,
    input  logic [DET_N-1:0]  wr_det,
    input  logic [EVT_N-1:0]  evt_in,
    input  logic [DET_N-1:0]  det_in,
    input  logic              drs_done,
    input  logic              wipe_done,
    input  logic              key_xfer,
    input  logic [DATA_W-1:0] rtc_sec,
    output logic              drs_req,
    output logic              wipe_req,
    output logic [DATA_W-1:0] ts_q,
    output logic [DATA_W-1:0] alarm_word,
    output logic [DATA_W-1:0] diag_word
);
    import secmon_pkg::*;

    logic [EVT_N-1:0] evt_q;
    logic [DET_N-1:0] det_q;
    logic             key_q;
    logic             drs_start;

    assign drs_start = wr_en && wr_trig[ALM_DRS_BIT] && !drs_req;

    // Destructive reset request: set by software, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)         drs_req <= 1'b0;
        else if (drs_req)   drs_req <= !drs_done;
        else if (drs_start) drs_req <= 1'b1;
    end

    // Key wipe request: set by software, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)        wipe_req <= 1'b0;
        else if (wipe_req) wipe_req <= !wipe_done;
        else if (wr_en && wr_trig[ALM_WIPE_BIT]) wipe_req <= 1'b1;
    end

    // Capture RTC seconds when a destructive reset is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)         ts_q <= '0;
        else if (drs_start) ts_q <= rtc_sec;
    end

    // Key-transferred bit: only the battery-on reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        key_q <= 1'b0;
        else if (key_xfer) key_q <= 1'b1;
    end

    for (genvar i = 0; i < EVT_N; i++) begin : g_evt
        // Sticky event flag, set wins over a written zero.
        always_ff @(posedge clk) begin
            if (!rst_n)                  evt_q[i] <= 1'b0;
            else if (evt_in[i])          evt_q[i] <= 1'b1;
            else if (wr_en && !wr_evt[i]) evt_q[i] <= 1'b0;
        end
    end

    for (genvar j = 0; j < DET_N; j++) begin : g_det
        // Sticky detect flag, set wins over a written zero.
        always_ff @(posedge clk) begin
            if (!rst_n)                  det_q[j] <= 1'b0;
            else if (det_in[j])          det_q[j] <= 1'b1;
            else if (wr_en && !wr_det[j]) det_q[j] <= 1'b0;
        end
    end

    // Assemble the readable alarm and diagnostic words.
    always_comb begin
        alarm_word = '0;
        diag_word  = '0;
        alarm_word[ALM_DRS_BIT]  = drs_req;
        alarm_word[ALM_WIPE_BIT] = wipe_req;
        for (int i = 0; i < EVT_N; i++) alarm_word[EVT_LSB+i] = evt_q[i];
        for (int j = 0; j < DET_N; j++) begin
            alarm_word[DET_LSB+j] = det_q[j];
            diag_word[DET_LSB+j]  = det_q[j];
        end
        diag_word[DIAG_BOR_BIT] = 1'b1;
        for (int k = 0; k < DIAG_MIRROR_N; k++) diag_word[EVT_LSB+k] = evt_q[k];
        diag_word[DIAG_ANYDET_BIT] = |det_q;
        diag_word[DIAG_KEY_BIT]    = key_q;
    end
endmodule

// File: rtl/secmon_regfile.sv
// Top of the security control register file: address decode, read mux,
// write error pulse. All state is cleared only by bat_rst_n.
// Assumes DATA_W = 32 so that the alarm fields fit their fixed positions,
// and that wr_en and rd_en are not raised in the same cycle.
module secmon_regfile #(
    parameter int DATA_W = 32,
    parameter int EVT_N  = 11,
    parameter int DET_N  = 6,
    parameter int SYNC_N = 2
) (
    input  logic                        clk,
    input  logic                        bat_rst_n,
    input  logic                        mon_clk,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [secmon_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output logic                        rd_valid,
    output logic                        wr_err,
    input  logic [EVT_N-1:0]            evt_in,
    input  logic [DET_N-1:0]            det_in,
    input  logic                        drs_done,
    input  logic                        wipe_done,
    input  logic                        key_xfer,
    input  logic [DATA_W-1:0]           rtc_sec,
    output logic                        drs_req,
    output logic                        wipe_req,
    output logic [DATA_W-2:0]           int_ctrl,
    output logic [DATA_W-3:0]           mon_ext_ctrl
);
    import secmon_pkg::*;

    localparam int LOCK_BIT = DATA_W - 1;
    localparam int BUSY_BIT = DATA_W - 2;
    localparam int EXT_W    = DATA_W - 2;
    localparam int INT_W    = DATA_W - 1;

    reg_sel_e          sel;
    logic [EXT_W-1:0]  ext_q;
    logic              ext_locked;
    logic              ext_busy;
    logic              ext_rejected;
    logic              int_locked;
    logic [DATA_W-1:0] ts_q;
    logic [DATA_W-1:0] alarm_word;
    logic [DATA_W-1:0] diag_word;
    logic [DATA_W-1:0] rd_mux;

    // Decode the byte offset into a register select.
    always_comb begin
        case (addr)
            OFS_EXT:  sel = SEL_EXT;
            OFS_INT:  sel = SEL_INT;
            OFS_ALM:  sel = SEL_ALM;
            OFS_DIAG: sel = SEL_DIAG;
            OFS_TS:   sel = SEL_TS;
            default:  sel = SEL_NONE;
        endcase
    end

    secmon_ext_xfer #(.W(EXT_W), .SYNC_N(SYNC_N)) u_ext (
        .clk      (clk),
        .rst_n    (bat_rst_n),
        .mon_clk  (mon_clk),
        .wr_req   (wr_en && sel == SEL_EXT),
        .wdata    (wdata[EXT_W-1:0]),
        .lock_in  (wdata[LOCK_BIT]),
        .ctrl_q   (ext_q),
        .locked   (ext_locked),
        .busy     (ext_busy),
        .rejected (ext_rejected),
        .mon_ctrl (mon_ext_ctrl)
    );

    secmon_lock_reg #(.W(INT_W)) u_int (
        .clk     (clk),
        .rst_n   (bat_rst_n),
        .wr_en   (wr_en && sel == SEL_INT),
        .wdata   (wdata[INT_W-1:0]),
        .lock_in (wdata[LOCK_BIT]),
        .q       (int_ctrl),
        .locked  (int_locked)
    );

    secmon_alarm #(.DATA_W(DATA_W), .EVT_N(EVT_N), .DET_N(DET_N)) u_alarm (
        .clk        (clk),
        .rst_n      (bat_rst_n),
        .wr_en      (wr_en && sel == SEL_ALM),
        .wr_trig    (wdata[1:0]),
        .wr_evt     (wdata[EVT_LSB +: EVT_N]),
        .wr_det     (wdata[DET_LSB +: DET_N]),
        .evt_in     (evt_in),
        .det_in     (det_in),
        .drs_done   (drs_done),
        .wipe_done  (wipe_done),
        .key_xfer   (key_xfer),
        .rtc_sec    (rtc_sec),
        .drs_req    (drs_req),
        .wipe_req   (wipe_req),
        .ts_q       (ts_q),
        .alarm_word (alarm_word),
        .diag_word  (diag_word)
    );

    // Select the word a read returns.
    always_comb begin
        case (sel)
            SEL_EXT:  rd_mux = {ext_locked, ext_busy, ext_q};
            SEL_INT:  rd_mux = {int_locked, int_ctrl};
            SEL_ALM:  rd_mux = alarm_word;
            SEL_DIAG: rd_mux = diag_word;
            SEL_TS:   rd_mux = ts_q;
            default:  rd_mux = '0;
        endcase
    end

    // Register read data, valid flag and the refused-write pulse.
    always_ff @(posedge clk) begin
        if (!bat_rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
            wr_err   <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            wr_err   <= ext_rejected;
            if (rd_en) rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/secmon_regfile_chk.sv
// Property checker for secmon_regfile, attached with bind below.
module secmon_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              bat_rst_n,
    input logic              rd_en,
    input logic              rd_valid,
    input logic              wr_err,
    input logic              ext_busy,
    input logic              ext_locked,
    input logic [DATA_W-3:0] ext_q,
    input logic [DATA_W-3:0] mon_ext_ctrl,
    input logic              int_locked,
    input logic [DATA_W-2:0] int_ctrl,
    input logic              drs_req,
    input logic              drs_done,
    input logic              wipe_req,
    input logic              wipe_done,
    input logic [DATA_W-1:0] ts_q,
    input logic              key_xfer,
    input logic              key_bit,
    input logic              evt0_in,
    input logic              evt0_flag
);
    // R3: busy only drops once the monitor holds the stored word.
    a_r3_busy_after_copy: assert property (@(posedge clk) disable iff (!bat_rst_n)
        $fell(ext_busy) |-> (mon_ext_ctrl == ext_q));

    // R4: a refusal follows a write made while busy.
    a_r4_err_needs_busy: assert property (@(posedge clk) disable iff (!bat_rst_n)
        wr_err |-> $past(ext_busy));

    // R5: the external lock never falls.
    a_r5_ext_lock_kept: assert property (@(posedge clk) disable iff (!bat_rst_n)
        ext_locked |=> ext_locked);

    // R5: a locked internal word holds still.
    a_r5_int_frozen: assert property (@(posedge clk) disable iff (!bat_rst_n)
        int_locked |=> (int_locked && $stable(int_ctrl)));

    // R7: the request holds until completion.
    a_r7_drs_hold: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (drs_req && !drs_done) |=> drs_req);

    // R8: the timestamp moves only as the request rises.
    a_r8_ts_on_rise: assert property (@(posedge clk) disable iff (!bat_rst_n)
        !$stable(ts_q) |-> $rose(drs_req));

    // R9: the wipe request holds until completion.
    a_r9_wipe_hold: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (wipe_req && !wipe_done) |=> wipe_req);

    // R10: a hardware pulse always leaves the flag set.
    a_r10_evt_sets: assert property (@(posedge clk) disable iff (!bat_rst_n)
        evt0_in |=> evt0_flag);

    // R11: the key pulse sets the diagnostic bit.
    a_r11_key_sets: assert property (@(posedge clk) disable iff (!bat_rst_n)
        key_xfer |=> key_bit);

    // R13: read data follows a read strobe.
    a_r13_valid_after_rd: assert property (@(posedge clk) disable iff (!bat_rst_n)
        rd_valid |-> $past(rd_en));
endmodule

bind secmon_regfile secmon_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .bat_rst_n    (bat_rst_n),
    .rd_en        (rd_en),
    .rd_valid     (rd_valid),
    .wr_err       (wr_err),
    .ext_busy     (ext_busy),
    .ext_locked   (ext_locked),
    .ext_q        (ext_q),
    .mon_ext_ctrl (mon_ext_ctrl),
    .int_locked   (int_locked),
    .int_ctrl     (int_ctrl),
    .drs_req      (drs_req),
    .drs_done     (drs_done),
    .wipe_req     (wipe_req),
    .wipe_done    (wipe_done),
    .ts_q         (ts_q),
    .key_xfer     (key_xfer),
    .key_bit      (diag_word[secmon_pkg::DIAG_KEY_BIT]),
    .evt0_in      (evt_in[0]),
    .evt0_flag    (alarm_word[secmon_pkg::EVT_LSB])
);

// File: tb/secmon_regfile_bench.sv
// Scoreboard bench: read tasks queue expected words, a monitor pops and
// compares them when rd_valid shows. Bus clock period 10 (100 MHz in ns).
module secmon_regfile_bench;
    localparam int DW = 32;
    localparam int EN = 11;
    localparam int DN = 6;

    logic          clk = 1'b0;
    logic          mon_clk = 1'b0;
    logic          bat_rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rd_valid;
    logic          wr_err;
    logic [EN-1:0] evt_in = '0;
    logic [DN-1:0] det_in = '0;
    logic          drs_done = 1'b0;
    logic          wipe_done = 1'b0;
    logic          key_xfer = 1'b0;
    logic [DW-1:0] rtc_sec = '0;
    logic          drs_req;
    logic          wipe_req;
    logic [DW-2:0] int_ctrl;
    logic [DW-3:0] mon_ext_ctrl;

    int vec_cnt = 0;
    int bad_cnt = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic          err;

    always #5 clk = ~clk;
    always #18 mon_clk = ~mon_clk;

    secmon_regfile u_secmon_regfile (
        .clk (clk), .bat_rst_n (bat_rst_n), .mon_clk (mon_clk),
        .wr_en (wr_en), .rd_en (rd_en), .addr (addr), .wdata (wdata),
        .rdata (rdata), .rd_valid (rd_valid), .wr_err (wr_err),
        .evt_in (evt_in), .det_in (det_in), .drs_done (drs_done),
        .wipe_done (wipe_done), .key_xfer (key_xfer), .rtc_sec (rtc_sec),
        .drs_req (drs_req), .wipe_req (wipe_req), .int_ctrl (int_ctrl),
        .mon_ext_ctrl (mon_ext_ctrl)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            bad_cnt++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each returned read with the queued expectation.
    always @(negedge clk) begin
        if (rd_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                vec_cnt++; bad_cnt++;
                $display("FAIL R13 unexpected read actual=%h expected=none", rdata);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [DW-1:0] d, output logic e);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; e = wr_err;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk); addr = a; rd_en = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic hw_pulse(input logic [EN-1:0] e, input logic [DN-1:0] d,
                            input logic key, input logic dd, input logic wd);
        @(negedge clk); evt_in = e; det_in = d; key_xfer = key; drs_done = dd; wipe_done = wd;
        @(negedge clk); evt_in = '0; det_in = '0; key_xfer = 1'b0; drs_done = 1'b0; wipe_done = 1'b0;
    endtask

    task automatic bat_reset();
        @(negedge clk); bat_rst_n = 1'b0;
        idle(24);
        bat_rst_n = 1'b1;
        idle(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        vec_cnt++; bad_cnt++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        bat_reset();
        // R1 reset state
        chk("R1 drs_req", {31'b0, drs_req}, 0);
        chk("R1 wipe_req", {31'b0, wipe_req}, 0);
        chk("R1 int_ctrl", {1'b0, int_ctrl}, 0);
        chk("R1 mon_ext_ctrl", {2'b0, mon_ext_ctrl}, 0);
        bus_rd(8'h00, 32'h0, "R1 ext");
        bus_rd(8'h04, 32'h0, "R1 int");
        bus_rd(8'h08, 32'h0, "R1 alarm");
        bus_rd(8'h0C, 32'h1, "R1 diag");
        bus_rd(8'h10, 32'h0, "R1 ts");
        bus_rd(8'h20, 32'h0, "R13 unmapped");

        // R2 accepted write, busy visible; R4 refused write while busy
        bus_wr(8'h00, 32'h4000_0ABC, err);
        chk("R2 no error", {31'b0, err}, 0);
        bus_wr(8'h00, 32'h0000_1111, err);
        chk("R4 wr_err", {31'b0, err}, 1);
        bus_rd(8'h00, 32'h4000_0ABC, "R2 busy readback");
        idle(40);
        // R3 busy cleared after transfer
        bus_rd(8'h00, 32'h0000_0ABC, "R3 idle readback");
        chk("R3 mon_ext_ctrl", {2'b0, mon_ext_ctrl}, 32'h0ABC);

        // R6 internal word
        bus_wr(8'h04, 32'h1234_5678, err);
        chk("R6 int_ctrl", {1'b0, int_ctrl}, 32'h1234_5678);
        bus_rd(8'h04, 32'h1234_5678, "R6 int readback");

        // R5 locks
        bus_wr(8'h04, 32'h8000_00FF, err);
        bus_wr(8'h04, 32'h0000_0001, err);
        bus_rd(8'h04, 32'h8000_00FF, "R5 int locked");
        chk("R5 int_ctrl frozen", {1'b0, int_ctrl}, 32'hFF);
        bus_wr(8'h00, 32'h8000_0055, err);
        idle(40);
        bus_wr(8'h00, 32'h0000_0001, err);
        chk("R5 locked no wr_err", {31'b0, err}, 0);
        idle(40);
        bus_rd(8'h00, 32'h8000_0055, "R5 ext locked");
        chk("R5 mon frozen", {2'b0, mon_ext_ctrl}, 32'h55);

        // R7/R8 destructive reset trigger and timestamp
        rtc_sec = 32'hCAFE_0001;
        bus_wr(8'h08, 32'h1, err);
        chk("R7 drs_req set", {31'b0, drs_req}, 1);
        bus_rd(8'h10, 32'hCAFE_0001, "R8 ts captured");
        rtc_sec = 32'h0000_0002;
        bus_wr(8'h08, 32'h1, err);
        bus_wr(8'h08, 32'h0, err);
        chk("R7 zero ignored", {31'b0, drs_req}, 1);
        bus_rd(8'h10, 32'hCAFE_0001, "R8 no recapture");
        bus_wr(8'h10, 32'h0, err);
        bus_rd(8'h10, 32'hCAFE_0001, "R8 write ignored");
        hw_pulse('0, '0, 1'b0, 1'b1, 1'b0);
        chk("R7 drs_req cleared", {31'b0, drs_req}, 0);

        // R9 key wipe
        rtc_sec = 32'h0000_5555;
        bus_wr(8'h08, 32'h2, err);
        chk("R9 wipe_req set", {31'b0, wipe_req}, 1);
        chk("R9 drs untouched", {31'b0, drs_req}, 0);
        bus_rd(8'h10, 32'hCAFE_0001, "R9 ts untouched");
        hw_pulse('0, '0, 1'b0, 1'b0, 1'b1);
        chk("R9 wipe_req cleared", {31'b0, wipe_req}, 0);

        // R10 sticky flags
        hw_pulse('1, '1, 1'b0, 1'b0, 1'b0);
        bus_rd(8'h08, 32'h003F_1FFC, "R10 flags set");
        bus_wr(8'h08, 32'hFFFF_FFFC, err);
        bus_rd(8'h08, 32'h003F_1FFC, "R10 write one no effect");
        bus_wr(8'h08, 32'h003F_1FF8, err);
        bus_rd(8'h08, 32'h003F_1FF8, "R10 clear one flag");
        bus_rd(8'h0C, 32'h003F_00F9, "R11 diag mirror");
        // R10 set and clear in the same cycle
        @(negedge clk); addr = 8'h08; wdata = 32'h0; wr_en = 1'b1; evt_in = 11'h001;
        @(negedge clk); wr_en = 1'b0; evt_in = '0;
        bus_rd(8'h08, 32'h0000_0004, "R10 set beats clear");

        // R11 key transferred bit
        hw_pulse('0, '0, 1'b1, 1'b0, 1'b0);
        bus_wr(8'h0C, 32'h0, err);
        bus_rd(8'h0C, 32'h0000_0105, "R11 key bit kept");

        // R12 battery reset releases locks
        bat_reset();
        bus_rd(8'h04, 32'h0, "R12 int cleared");
        bus_rd(8'h00, 32'h0, "R12 ext cleared");
        bus_rd(8'h0C, 32'h1, "R12 diag cleared");
        bus_wr(8'h04, 32'h0000_0042, err);
        chk("R12 int writable", {1'b0, int_ctrl}, 32'h42);
        idle(6);
        chk("R12 mon cleared", {2'b0, mon_ext_ctrl}, 0);
        chk("R13 queue drained", exp_q.size(), 0);

        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end
endmodule